// File: doc/BRIEF.md
# Set-Associative Longest-Prefix Lookup Engine

This block is the lookup datapath of a hash-based IPv4 forwarding engine. Each request carries a 32-bit destination address, the row index a hashing stage has already worked out, and the tag for that address. The block reads every way of the chosen row in one access. It compares each stored entry against the tag, using only as many leading bits as the entry's prefix length. The longest matching prefix supplies the next hop.

A small fully associative overflow store holds prefixes that found no free bucket. It is searched against the full address on every lookup, alongside the hashed row. The two candidates are then merged by prefix length.

The engine is a three-stage pipeline with valid/ready flow control. Stage one reads the row, stage two compares, stage three selects. It accepts one request per cycle. A back-pressured output stalls the whole pipe. An insertion block outside this one fills both stores through a simple write port.

Top module: `lpm_lookup`

## Requirements
- R1: After reset, out_valid_o is low, in_ready_o is high and every entry of both stores is invalid, so any lookup reports a miss.
- R2: A lookup examines only the ways of the row given by row_i. Entries in other rows never affect its result.
- R3: A hash entry matches when its valid bit is set and its tag equals tag_i on the leading (most significant) len bits. Tag bits beyond the length are ignored.
- R4: When several ways of the row match, the longest length wins. On equal lengths the lowest way index wins.
- R5: The overflow store is searched on every lookup. A slot matches when it is valid and its 32-bit key equals addr_i on the leading len bits. Among matching slots the longest wins, and on a tie the lowest slot index wins.
- R6: If both stores hit, the longer prefix is reported. On equal lengths the hash result is reported. ovf_o is 1 exactly when the reported result came from the overflow store.
- R7: When nothing matches, miss_o is 1, and len_o, hop_o and ovf_o are all 0.
- R8: An entry whose stored length lies outside 8..32 never matches, in either store.
- R9: A request accepted on a rising edge is presented on the outputs after the second edge that follows it. Back-to-back requests produce results on consecutive cycles.
- R10: While out_valid_o is 1 and out_ready_i is 0, the outputs hold steady, in_ready_o is 0 and no result is lost.
- R11: With tbl_we_i (hash, selected by wr_row_i and the way in wr_slot_i) or ovf_we_i (overflow slot wr_slot_i), the entry is written on the rising edge. Lookups accepted on later edges see it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Request valid |
| in_ready_o | output | 1 | Request accepted when high |
| addr_i | input | 32 | Destination address |
| row_i | input | ROW_W | Hashed row index |
| tag_i | input | TAG_W | Tag, most significant bit first |
| out_valid_o | output | 1 | Result valid |
| out_ready_i | input | 1 | Downstream accepts result |
| miss_o | output | 1 | No entry matched |
| ovf_o | output | 1 | Result came from the overflow store |
| len_o | output | 6 | Length of the winning prefix |
| hop_o | output | 8 | Next hop of the winning prefix |
| tbl_we_i | input | 1 | Write a hash entry |
| ovf_we_i | input | 1 | Write an overflow slot |
| wr_row_i | input | ROW_W | Row for a hash write |
| wr_slot_i | input | SLOT_W | Way or overflow slot to write |
| wr_vld_i | input | 1 | Valid bit to write |
| wr_len_i | input | 6 | Prefix length to write |
| wr_key_i | input | 32 | Key; the hash tag is its top TAG_W bits |
| wr_hop_i | input | 8 | Next hop to write |

## Verification
The hardest cases to reach are the priority corners. These need one row holding several overlapping prefixes: two of equal length, plus an overflow slot that ties one of them and another that outranks it. The stimulus therefore fills a single row and the overflow store with nested prefixes, then walks addresses that peel them away one length at a time. Out-of-range lengths and cleared valid bits are placed where they would otherwise win. The vectors stream back to back to show one result per cycle, and a separate stall keeps a result waiting at the output.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  parameter int ADDR_W  = 32;
  parameter int HOP_W   = 8;
  parameter int LEN_W   = 6;
  parameter int MIN_LEN = 8;
  parameter int MAX_LEN = 32;

  typedef struct packed {
    logic             miss;
    logic             ovf;
    logic [LEN_W-1:0] len;
    logic [HOP_W-1:0] hop;
  } lpm_res_t;
endpackage

// File: rtl/lpm_match.sv
module lpm_match
  import lpm_pkg::*;
#(
  parameter int N = 4,
  parameter int W = 32
) (
  input  logic [N-1:0]            vld_i,
  input  logic [N-1:0][LEN_W-1:0] len_i,
  input  logic [N-1:0][W-1:0]     key_i,
  input  logic [W-1:0]            probe_i,
  output logic [N-1:0]            match_o
);
  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic [W-1:0] mask;
    logic         len_ok;
    always_comb begin
      for (int b = 0; b < W; b++) mask[b] = (W - 1 - b) < int'(len_i[g]);
    end
    assign len_ok     = (int'(len_i[g]) >= MIN_LEN) && (int'(len_i[g]) <= MAX_LEN);
    assign match_o[g] = vld_i[g] && len_ok && (((key_i[g] ^ probe_i) & mask) == '0);
  end
endmodule

// File: rtl/lpm_pick.sv
module lpm_pick
  import lpm_pkg::*;
#(
  parameter int N = 4
) (
  input  logic [N-1:0]            match_i,
  input  logic [N-1:0][LEN_W-1:0] len_i,
  input  logic [N-1:0][HOP_W-1:0] hop_i,
  output logic                    hit_o,
  output logic [LEN_W-1:0]        len_o,
  output logic [HOP_W-1:0]        hop_o
);
  // strict compare keeps the lowest index on equal lengths
  always_comb begin
    hit_o = 1'b0;
    len_o = '0;
    hop_o = '0;
    for (int i = 0; i < N; i++) begin
      if (match_i[i] && (!hit_o || len_i[i] > len_o)) begin
        hit_o = 1'b1;
        len_o = len_i[i];
        hop_o = hop_i[i];
      end
    end
  end

  always_comb begin
    if (match_i == '0) a_r4_no_match_no_hit : assert (!hit_o);
  end
endmodule

// File: rtl/lpm_lookup.sv
module lpm_lookup
  import lpm_pkg::*;
#(
  parameter int ROW_W  = 4,
  parameter int WAYS   = 4,
  parameter int OVF_N  = 4,
  parameter int TAG_W  = 32,
  localparam int ROWS   = 1 << ROW_W,
  localparam int WAY_IW = $clog2(WAYS),
  localparam int OVF_IW = $clog2(OVF_N),
  localparam int SLOT_W = (WAY_IW > OVF_IW) ? WAY_IW : OVF_IW
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              in_valid_i,
  output logic              in_ready_o,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ROW_W-1:0]  row_i,
  input  logic [TAG_W-1:0]  tag_i,
  output logic              out_valid_o,
  input  logic              out_ready_i,
  output logic              miss_o,
  output logic              ovf_o,
  output logic [LEN_W-1:0]  len_o,
  output logic [HOP_W-1:0]  hop_o,
  input  logic              tbl_we_i,
  input  logic              ovf_we_i,
  input  logic [ROW_W-1:0]  wr_row_i,
  input  logic [SLOT_W-1:0] wr_slot_i,
  input  logic              wr_vld_i,
  input  logic [LEN_W-1:0]  wr_len_i,
  input  logic [ADDR_W-1:0] wr_key_i,
  input  logic [HOP_W-1:0]  wr_hop_i
);
  // hash table storage
  logic [WAYS-1:0]            tv_q [ROWS];
  logic [WAYS-1:0][LEN_W-1:0] tl_q [ROWS];
  logic [WAYS-1:0][TAG_W-1:0] tt_q [ROWS];
  logic [WAYS-1:0][HOP_W-1:0] th_q [ROWS];
  // overflow store
  logic [OVF_N-1:0]             ov_q;
  logic [OVF_N-1:0][LEN_W-1:0]  ol_q;
  logic [OVF_N-1:0][ADDR_W-1:0] ok_q;
  logic [OVF_N-1:0][HOP_W-1:0]  oh_q;

  logic [WAY_IW-1:0] wr_way;
  logic [OVF_IW-1:0] wr_ovf;
  assign wr_way = wr_slot_i[WAY_IW-1:0];
  assign wr_ovf = wr_slot_i[OVF_IW-1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int r = 0; r < ROWS; r++) begin
        tv_q[r] <= '0;
        tl_q[r] <= '0;
        tt_q[r] <= '0;
        th_q[r] <= '0;
      end
      ov_q <= '0;
      ol_q <= '0;
      ok_q <= '0;
      oh_q <= '0;
    end else begin
      if (tbl_we_i) begin
        tv_q[wr_row_i][wr_way] <= wr_vld_i;
        tl_q[wr_row_i][wr_way] <= wr_len_i;
        tt_q[wr_row_i][wr_way] <= wr_key_i[ADDR_W-1 -: TAG_W];
        th_q[wr_row_i][wr_way] <= wr_hop_i;
      end
      if (ovf_we_i) begin
        ov_q[wr_ovf] <= wr_vld_i;
        ol_q[wr_ovf] <= wr_len_i;
        ok_q[wr_ovf] <= wr_key_i;
        oh_q[wr_ovf] <= wr_hop_i;
      end
    end
  end

  // global stall: the whole pipe advances only when the output can move
  logic adv;
  assign adv        = !out_valid_o || out_ready_i;
  assign in_ready_o = adv;

  // stage 1: row read
  logic                       s1_vld;
  logic [ADDR_W-1:0]          s1_addr;
  logic [TAG_W-1:0]           s1_tag;
  logic [WAYS-1:0]            s1_tv;
  logic [WAYS-1:0][LEN_W-1:0] s1_tl;
  logic [WAYS-1:0][TAG_W-1:0] s1_tt;
  logic [WAYS-1:0][HOP_W-1:0] s1_th;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_vld  <= 1'b0;
      s1_addr <= '0;
      s1_tag  <= '0;
      s1_tv   <= '0;
      s1_tl   <= '0;
      s1_tt   <= '0;
      s1_th   <= '0;
    end else if (adv) begin
      s1_vld <= in_valid_i;
      if (in_valid_i) begin
        s1_addr <= addr_i;
        s1_tag  <= tag_i;
        s1_tv   <= tv_q[row_i];
        s1_tl   <= tl_q[row_i];
        s1_tt   <= tt_q[row_i];
        s1_th   <= th_q[row_i];
      end
    end
  end

  // stage 2: parallel compare of all ways and all overflow slots
  logic [WAYS-1:0]  h_match;
  logic [OVF_N-1:0] o_match;

  lpm_match #(.N(WAYS), .W(TAG_W)) u_hash_cmp (
    .vld_i(s1_tv), .len_i(s1_tl), .key_i(s1_tt), .probe_i(s1_tag), .match_o(h_match)
  );
  lpm_match #(.N(OVF_N), .W(ADDR_W)) u_ovf_cmp (
    .vld_i(ov_q), .len_i(ol_q), .key_i(ok_q), .probe_i(s1_addr), .match_o(o_match)
  );

  logic                        s2_vld;
  logic [WAYS-1:0]             s2_hm;
  logic [WAYS-1:0][LEN_W-1:0]  s2_hl;
  logic [WAYS-1:0][HOP_W-1:0]  s2_hh;
  logic [OVF_N-1:0]            s2_om;
  logic [OVF_N-1:0][LEN_W-1:0] s2_ol;
  logic [OVF_N-1:0][HOP_W-1:0] s2_oh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s2_vld <= 1'b0;
      s2_hm  <= '0;
      s2_hl  <= '0;
      s2_hh  <= '0;
      s2_om  <= '0;
      s2_ol  <= '0;
      s2_oh  <= '0;
    end else if (adv) begin
      s2_vld <= s1_vld;
      s2_hm  <= h_match;
      s2_hl  <= s1_tl;
      s2_hh  <= s1_th;
      s2_om  <= o_match;
      s2_ol  <= ol_q;
      s2_oh  <= oh_q;
    end
  end

  // stage 3: priority select and merge
  logic             h_hit, o_hit, take_h;
  logic [LEN_W-1:0] h_len, o_len;
  logic [HOP_W-1:0] h_hop, o_hop;
  lpm_res_t         res_d, res_q;

  lpm_pick #(.N(WAYS)) u_hash_pick (
    .match_i(s2_hm), .len_i(s2_hl), .hop_i(s2_hh),
    .hit_o(h_hit), .len_o(h_len), .hop_o(h_hop)
  );
  lpm_pick #(.N(OVF_N)) u_ovf_pick (
    .match_i(s2_om), .len_i(s2_ol), .hop_i(s2_oh),
    .hit_o(o_hit), .len_o(o_len), .hop_o(o_hop)
  );

  assign take_h = h_hit && (!o_hit || h_len >= o_len);

  always_comb begin
    res_d = '{miss: 1'b1, ovf: 1'b0, len: '0, hop: '0};
    if (take_h)     res_d = '{miss: 1'b0, ovf: 1'b0, len: h_len, hop: h_hop};
    else if (o_hit) res_d = '{miss: 1'b0, ovf: 1'b1, len: o_len, hop: o_hop};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_valid_o <= 1'b0;
      res_q       <= '{miss: 1'b1, ovf: 1'b0, len: '0, hop: '0};
    end else if (adv) begin
      out_valid_o <= s2_vld;
      res_q       <= res_d;
    end
  end

  assign miss_o = res_q.miss;
  assign ovf_o  = res_q.ovf;
  assign len_o  = res_q.len;
  assign hop_o  = res_q.hop;

  a_r7_miss_clean : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && miss_o |-> (len_o == '0) && (hop_o == '0) && !ovf_o);
  a_r8_len_range : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !miss_o |-> (int'(len_o) >= MIN_LEN) && (int'(len_o) <= MAX_LEN));
  a_r10_hold : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |=> out_valid_o && $stable(res_q));
  a_r10_no_accept : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && !out_ready_i |-> !in_ready_o);
  a_r6_ovf_is_hit : assert property (@(posedge clk_i) disable iff (!rst_ni)
    out_valid_o && ovf_o |-> !miss_o);
endmodule

// File: tb/lpm_lookup_bench.sv
module lpm_lookup_bench;
  import lpm_pkg::*;

  logic              clk_i = 1'b0;
  logic              rst_ni = 1'b0;
  logic              in_valid_i = 1'b0;
  logic              in_ready_o;
  logic [31:0]       addr_i = '0;
  logic [3:0]        row_i = '0;
  logic [31:0]       tag_i = '0;
  logic              out_valid_o;
  logic              out_ready_i = 1'b1;
  logic              miss_o, ovf_o;
  logic [5:0]        len_o;
  logic [7:0]        hop_o;
  logic              tbl_we_i = 1'b0, ovf_we_i = 1'b0;
  logic [3:0]        wr_row_i = '0;
  logic [1:0]        wr_slot_i = '0;
  logic              wr_vld_i = 1'b0;
  logic [5:0]        wr_len_i = '0;
  logic [31:0]       wr_key_i = '0;
  logic [7:0]        wr_hop_i = '0;

  always #4 clk_i = ~clk_i;

  lpm_lookup u_lpm_lookup (.*);

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  always @(posedge clk_i) cyc <= cyc + 1;

  typedef struct packed {
    logic [31:0] addr;
    logic [3:0]  row;
    logic        miss;
    logic        ovf;
    logic [5:0]  len;
    logic [7:0]  hop;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{32'h0A010203, 4'd3, 1'b0, 1'b0, 6'd24, 8'h33}, // R6 tie -> hash
    '{32'h0A010213, 4'd3, 1'b0, 1'b1, 6'd28, 8'hAA}, // R5 R6 longer overflow
    '{32'h0A01FF00, 4'd3, 1'b0, 1'b0, 6'd16, 8'h22}, // R4 tie -> lowest way
    '{32'h0AFF0000, 4'd3, 1'b0, 1'b0, 6'd8,  8'h11}, // R3
    '{32'h0AFF0000, 4'd5, 1'b0, 1'b0, 6'd8,  8'h55}, // R2 R8
    '{32'h0B000000, 4'd5, 1'b1, 1'b0, 6'd0,  8'h00}, // R8 R7
    '{32'hC0A80001, 4'd5, 1'b0, 1'b0, 6'd32, 8'h77}, // R6 R8
    '{32'hC0A12345, 4'd5, 1'b0, 1'b1, 6'd12, 8'hBB}, // R5
    '{32'hC0000000, 4'd5, 1'b1, 1'b0, 6'd0,  8'h00}, // R3 valid bit
    '{32'h0A010203, 4'd0, 1'b0, 1'b1, 6'd24, 8'h99}, // R2 R5
    '{32'h12345678, 4'd7, 1'b1, 1'b0, 6'd0,  8'h00}  // R7
  };

  task automatic chk(input string req, input bit ok, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic chk_res(input string req, input vec_t v);
    logic [15:0] act, exp;
    act = {miss_o, ovf_o, len_o, hop_o};
    exp = {v.miss, v.ovf, v.len, v.hop};
    chk(req, out_valid_o && act == exp, {47'd0, out_valid_o, act}, {48'd1, exp});
  endtask

  task automatic wr(input bit ovf, input logic [3:0] row, input logic [1:0] slot,
                    input logic vld, input logic [5:0] len, input logic [31:0] key, input logic [7:0] hop);
    @(negedge clk_i);
    tbl_we_i = !ovf; ovf_we_i = ovf;
    wr_row_i = row; wr_slot_i = slot; wr_vld_i = vld; wr_len_i = len; wr_key_i = key; wr_hop_i = hop;
    @(negedge clk_i);
    tbl_we_i = 1'b0; ovf_we_i = 1'b0;
  endtask

  // single lookup; returns at the negedge after the third edge
  task automatic one(input vec_t v);
    @(negedge clk_i);
    in_valid_i = 1'b1; addr_i = v.addr; tag_i = v.addr; row_i = v.row;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    repeat (20000) @(posedge clk_i);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    vec_t v;
    int first_c, last_c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 out_valid", out_valid_o == 1'b0, out_valid_o, 0);
    chk("R1 in_ready", in_ready_o == 1'b1, in_ready_o, 1);
    one('{32'h0A010203, 4'd3, 1'b0, 1'b0, 6'd0, 8'h00});
    chk_res("R1 empty miss", '{32'h0, 4'd0, 1'b1, 1'b0, 6'd0, 8'h00});

    wr(0, 4'd3, 2'd0, 1, 6'd8,  32'h0A000000, 8'h11);
    wr(0, 4'd3, 2'd1, 1, 6'd16, 32'h0A010000, 8'h22);
    wr(0, 4'd3, 2'd2, 1, 6'd24, 32'h0A010200, 8'h33);
    wr(0, 4'd3, 2'd3, 1, 6'd16, 32'h0A010000, 8'h44);
    wr(0, 4'd5, 2'd0, 1, 6'd8,  32'h0A000000, 8'h55);
    wr(0, 4'd5, 2'd1, 1, 6'd4,  32'h0A000000, 8'h66);
    wr(0, 4'd5, 2'd2, 1, 6'd32, 32'hC0A80001, 8'h77);
    wr(0, 4'd5, 2'd3, 0, 6'd8,  32'hC0000000, 8'h88);
    wr(1, 4'd0, 2'd0, 1, 6'd24, 32'h0A010200, 8'h99);
    wr(1, 4'd0, 2'd1, 1, 6'd28, 32'h0A010210, 8'hAA);
    wr(1, 4'd0, 2'd2, 1, 6'd12, 32'hC0A00000, 8'hBB);
    wr(1, 4'd0, 2'd3, 1, 6'd33, 32'hC0A80001, 8'hCC);

    // R9 latency on a single request
    @(negedge clk_i);
    in_valid_i = 1'b1; addr_i = VECS[3].addr; tag_i = VECS[3].addr; row_i = VECS[3].row;
    @(negedge clk_i);
    in_valid_i = 1'b0;
    @(negedge clk_i);
    chk("R9 not early", out_valid_o == 1'b0, out_valid_o, 0);
    @(negedge clk_i);
    chk_res("R9 latency", VECS[3]);
    @(negedge clk_i);

    // streamed vectors, R9 back-to-back
    first_c = 0; last_c = 0;
    fork
      begin
        for (int i = 0; i < NV; i++) begin
          in_valid_i = 1'b1; addr_i = VECS[i].addr; tag_i = VECS[i].addr; row_i = VECS[i].row;
          @(negedge clk_i);
        end
        in_valid_i = 1'b0;
      end
      begin
        for (int k = 0; k < NV; k++) begin
          @(negedge clk_i);
          while (!out_valid_o) @(negedge clk_i);
          if (k == 0) first_c = cyc;
          last_c = cyc;
          chk_res($sformatf("R2-vector %0d R3 R4 R5 R6 R7 R8", k), VECS[k]);
        end
      end
    join
    chk("R9 throughput", last_c - first_c == NV - 1, last_c - first_c, NV - 1);

    // R10 stall
    @(negedge clk_i);
    out_ready_i = 1'b0;
    one(VECS[1]);
    chk_res("R10 held result", VECS[1]);
    chk("R10 in_ready low", in_ready_o == 1'b0, in_ready_o, 0);
    repeat (3) @(negedge clk_i);
    chk_res("R10 still held", VECS[1]);
    out_ready_i = 1'b1;
    @(negedge clk_i);
    chk("R10 drained", out_valid_o == 1'b0, out_valid_o, 0);

    // R11 write then lookup
    wr(0, 4'd7, 2'd0, 1, 6'd8, 32'h12000000, 8'hDD);
    one(VECS[10]);
    chk_res("R11 new entry", '{32'h0, 4'd0, 1'b0, 1'b0, 6'd8, 8'hDD});
    wr(1, 4'd0, 2'd1, 0, 6'd28, 32'h0A010210, 8'hAA);
    one(VECS[1]);
    chk_res("R11 cleared slot", '{32'h0, 4'd0, 1'b0, 1'b0, 6'd24, 8'h33});

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule